// File: doc/BRIEF.md
# Dual-FIFO Bus Read Controller

This block arbitrates a shared microcontroller data bus between two sensor sample FIFOs. The microcontroller raises a read strobe together with a two-bit select code. The code asks for the next word of the first FIFO, the next word of the second FIFO, or a status word that packs the empty and full flags of both FIFOs into the low-order bus bits. The controller raises the pop strobe of the chosen FIFO and steers the matching word onto the bus. When no read is asked for, it releases the bus to high impedance.

Outside read cycles the controller produces one write strobe that loads a new sample into both FIFOs together. It holds that strobe back while either FIFO is full, so the two queues stay in step. Reads and writes never share a cycle. The block is purely combinational: every output follows its inputs within the same cycle.

Top module: `dual_fifo_bus_ctrl`

## Requirements
- R1: Select code encoding: 2'b00 idle, 2'b01 first FIFO data, 2'b10 second FIFO data, 2'b11 status word.
- R2: `pop_a_o` is high only when `rd_i` is high, select is 2'b01 and `empty_a_i` is low. `pop_b_o` is high only when `rd_i` is high, select is 2'b10 and `empty_b_i` is low.
- R3: `wr_o` is high exactly when `rd_i` is low and both `full_a_i` and `full_b_i` are low.
- R4: A pop strobe and the write strobe are never high in the same cycle, and the two pop strobes are never high together.
- R5: `bus_en_o` is high exactly when `rd_i` is high and select is not 2'b00. Otherwise the bus is high impedance and the select and data inputs have no effect on any output.
- R6: A data read from a non-empty FIFO places that FIFO's input word on `bus_o` unchanged.
- R7: A data read from an empty FIFO places all zeros on the bus.
- R8: The status word has bit0 = empty_a, bit1 = full_a, bit2 = empty_b, bit3 = full_b, and all higher bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_i | input | 1 | Read cycle strobe from the microcontroller |
| sel_i | input | 2 | Read source select code |
| data_a_i | input | 8 | Output word of the first FIFO |
| data_b_i | input | 8 | Output word of the second FIFO |
| empty_a_i | input | 1 | First FIFO empty flag |
| full_a_i | input | 1 | First FIFO full flag |
| empty_b_i | input | 1 | Second FIFO empty flag |
| full_b_i | input | 1 | Second FIFO full flag |
| pop_a_o | output | 1 | Pop strobe to the first FIFO |
| pop_b_o | output | 1 | Pop strobe to the second FIFO |
| wr_o | output | 1 | Shared push strobe to both FIFOs |
| bus_en_o | output | 1 | Bus driver enable |
| bus_o | output | 8 | Bus data, high impedance when not enabled |

## Verification
The block has no state, so any decoding fault shows at the ports in the same cycle as the input pattern that exposes it. Examples are a pop granted to an empty FIFO, a write left high beside a full flag, a swapped status bit, or stale data instead of zeros. The bench sweeps every combination of read strobe, select code and the four flags with changing data words. It compares every output against a behavioural model on every cycle. Two such models also run in the bench, one per FIFO, so that real sequences of fill and drain are checked.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  typedef enum logic [1:0] {
    SEL_IDLE   = 2'b00,
    SEL_DATA_A = 2'b01,
    SEL_DATA_B = 2'b10,
    SEL_STATUS = 2'b11
  } sel_e;

  typedef struct packed {
    logic want_a;
    logic want_b;
    logic want_stat;
  } req_t;

  localparam int STAT_BITS = 4;

  function automatic logic [STAT_BITS-1:0] pack_status(
    input logic ea, input logic fa, input logic eb, input logic fb);
    return {fb, eb, fa, ea};
  endfunction

endpackage

// File: rtl/dfc_decode.sv
module dfc_decode
  import dfc_pkg::*;
(
  input  logic       rd_i,
  input  logic [1:0] sel_i,
  output req_t       req_o
);
  always_comb begin
    req_o = '0;
    if (rd_i) begin
      unique case (sel_e'(sel_i))
        SEL_DATA_A: req_o.want_a    = 1'b1;
        SEL_DATA_B: req_o.want_b    = 1'b1;
        SEL_STATUS: req_o.want_stat = 1'b1;
        default:    req_o           = '0;
      endcase
    end
  end
endmodule

// File: rtl/dfc_strobe.sv
module dfc_strobe
  import dfc_pkg::*;
(
  input  logic rd_i,
  input  req_t req_i,
  input  logic empty_a_i,
  input  logic empty_b_i,
  input  logic full_a_i,
  input  logic full_b_i,
  output logic pop_a_o,
  output logic pop_b_o,
  output logic wr_o
);
  assign pop_a_o = req_i.want_a & ~empty_a_i;
  assign pop_b_o = req_i.want_b & ~empty_b_i;
  assign wr_o    = ~rd_i & ~(full_a_i | full_b_i);
endmodule

// File: rtl/dfc_busmux.sv
module dfc_busmux
  import dfc_pkg::*;
#(
  parameter int DW = 8
) (
  input  req_t          req_i,
  input  logic [DW-1:0] data_a_i,
  input  logic [DW-1:0] data_b_i,
  input  logic          empty_a_i,
  input  logic          full_a_i,
  input  logic          empty_b_i,
  input  logic          full_b_i,
  output logic          en_o,
  output logic [DW-1:0] val_o
);
  localparam int PAD = DW - STAT_BITS;

  logic [DW-1:0] stat_word;

  generate
    if (PAD > 0) begin : g_pad
      assign stat_word = {{PAD{1'b0}},
                          pack_status(empty_a_i, full_a_i, empty_b_i, full_b_i)};
    end else begin : g_nopad
      assign stat_word = DW'(pack_status(empty_a_i, full_a_i, empty_b_i, full_b_i));
    end
  endgenerate

  assign en_o = req_i.want_a | req_i.want_b | req_i.want_stat;

  always_comb begin
    val_o = '0;
    if (req_i.want_a && !empty_a_i) val_o = data_a_i;
    else if (req_i.want_b && !empty_b_i) val_o = data_b_i;
    else if (req_i.want_stat) val_o = stat_word;
  end
endmodule

// File: rtl/dual_fifo_bus_ctrl.sv
module dual_fifo_bus_ctrl
  import dfc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          rd_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] data_a_i,
  input  logic [DW-1:0] data_b_i,
  input  logic          empty_a_i,
  input  logic          full_a_i,
  input  logic          empty_b_i,
  input  logic          full_b_i,
  output logic          pop_a_o,
  output logic          pop_b_o,
  output logic          wr_o,
  output logic          bus_en_o,
  output logic [DW-1:0] bus_o
);
  req_t          req;
  logic [DW-1:0] bus_val;

  dfc_decode u_decode (
    .rd_i  (rd_i),
    .sel_i (sel_i),
    .req_o (req)
  );

  dfc_strobe u_strobe (
    .rd_i      (rd_i),
    .req_i     (req),
    .empty_a_i (empty_a_i),
    .empty_b_i (empty_b_i),
    .full_a_i  (full_a_i),
    .full_b_i  (full_b_i),
    .pop_a_o   (pop_a_o),
    .pop_b_o   (pop_b_o),
    .wr_o      (wr_o)
  );

  dfc_busmux #(.DW(DW)) u_busmux (
    .req_i     (req),
    .data_a_i  (data_a_i),
    .data_b_i  (data_b_i),
    .empty_a_i (empty_a_i),
    .full_a_i  (full_a_i),
    .empty_b_i (empty_b_i),
    .full_b_i  (full_b_i),
    .en_o      (bus_en_o),
    .val_o     (bus_val)
  );

  assign bus_o = bus_en_o ? bus_val : 'z;
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker #(
  parameter int DW = 8
) (
  input logic          rd_i,
  input logic [1:0]    sel_i,
  input logic [DW-1:0] data_a_i,
  input logic [DW-1:0] data_b_i,
  input logic          empty_a_i,
  input logic          full_a_i,
  input logic          empty_b_i,
  input logic          full_b_i,
  input logic          pop_a_o,
  input logic          pop_b_o,
  input logic          wr_o,
  input logic          bus_en_o,
  input logic [DW-1:0] bus_val
);
  always_comb begin
    if (!$isunknown({rd_i, sel_i, empty_a_i, empty_b_i, full_a_i, full_b_i})) begin
      // R2
      pop_a_empty_chk: assert (!(pop_a_o && empty_a_i));
      // R2
      pop_b_empty_chk: assert (!(pop_b_o && empty_b_i));
      // R4
      pop_wr_excl_chk: assert (!((pop_a_o || pop_b_o) && wr_o));
      // R4
      pop_pair_chk: assert ($countones({pop_a_o, pop_b_o}) <= 1);
      // R3
      wr_full_chk: assert (!(wr_o && (full_a_i || full_b_i || rd_i)));
      // R5
      bus_idle_chk: assert (!(bus_en_o && !rd_i));
      // R6
      pop_a_bus_chk: assert (!pop_a_o || (bus_en_o && bus_val == data_a_i));
      // R6
      pop_b_bus_chk: assert (!pop_b_o || (bus_en_o && bus_val == data_b_i));
      // R8
      stat_hi_chk: assert (!(bus_en_o && sel_i == 2'b11) || (bus_val >> 4) == '0);
    end
  end
endmodule

bind dual_fifo_bus_ctrl dfc_checker #(.DW(DW)) u_dfc_checker (
  .rd_i      (rd_i),
  .sel_i     (sel_i),
  .data_a_i  (data_a_i),
  .data_b_i  (data_b_i),
  .empty_a_i (empty_a_i),
  .full_a_i  (full_a_i),
  .empty_b_i (empty_b_i),
  .full_b_i  (full_b_i),
  .pop_a_o   (pop_a_o),
  .pop_b_o   (pop_b_o),
  .wr_o      (wr_o),
  .bus_en_o  (bus_en_o),
  .bus_val   (bus_val)
);

// File: tb/dual_fifo_bus_ctrl_bench.sv
module dual_fifo_bus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rd_i = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic [7:0] data_a_i = '0, data_b_i = '0;
  logic       empty_a_i = 1'b1, full_a_i = 1'b0, empty_b_i = 1'b1, full_b_i = 1'b0;
  logic       pop_a_o, pop_b_o, wr_o, bus_en_o;
  logic [7:0] bus_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_fifo_bus_ctrl u_dual_fifo_bus_ctrl (
    .rd_i(rd_i), .sel_i(sel_i), .data_a_i(data_a_i), .data_b_i(data_b_i),
    .empty_a_i(empty_a_i), .full_a_i(full_a_i), .empty_b_i(empty_b_i),
    .full_b_i(full_b_i), .pop_a_o(pop_a_o), .pop_b_o(pop_b_o), .wr_o(wr_o),
    .bus_en_o(bus_en_o), .bus_o(bus_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: compare all outputs for the current inputs
  task automatic compare_all();
    bit exp_en, exp_pa, exp_pb, exp_wr;
    int exp_val;
    exp_en = rd_i && (sel_i != 0);                              // R1 R5
    exp_pa = rd_i && sel_i == 1 && !empty_a_i;                  // R2
    exp_pb = rd_i && sel_i == 2 && !empty_b_i;                  // R2
    exp_wr = !rd_i && !full_a_i && !full_b_i;                   // R3
    if (sel_i == 1)      exp_val = empty_a_i ? 0 : int'(data_a_i);   // R6 R7
    else if (sel_i == 2) exp_val = empty_b_i ? 0 : int'(data_b_i);
    else                 exp_val = int'(empty_a_i) + 2*int'(full_a_i)
                                  + 4*int'(empty_b_i) + 8*int'(full_b_i); // R8
    chk("R2 pop_a", int'(pop_a_o), int'(exp_pa));
    chk("R2 pop_b", int'(pop_b_o), int'(exp_pb));
    chk("R3 wr", int'(wr_o), int'(exp_wr));
    chk("R5 bus_en", int'(bus_en_o), int'(exp_en));
    chk("R4 strobe exclusion", int'((pop_a_o | pop_b_o) & wr_o), 0);
    if (exp_en) begin
      if (sel_i == 3) chk("R8 status word", int'(bus_o), exp_val);
      else if ((sel_i == 1 && empty_a_i) || (sel_i == 2 && empty_b_i))
        chk("R7 empty read zero", int'(bus_o), 0);
      else chk("R6 data word", int'(bus_o), exp_val);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare_all();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    byte unsigned qa[$];
    byte unsigned qb[$];
    byte unsigned nxt;
    @(negedge clk);
    // initial idle state: nothing requested
    step();

    // exhaustive sweep: R1 R2 R3 R5 R6 R7 R8
    for (int k = 0; k < 128; k++) begin
      {rd_i, sel_i, empty_a_i, full_a_i, empty_b_i, full_b_i} = 7'(k);
      data_a_i = 8'(k * 37 + 5);
      data_b_i = 8'(k * 91 + 200);
      step();
    end

    // R5: with rd low, select/data changes leave strobes and bus idle
    rd_i = 0; empty_a_i = 0; empty_b_i = 0; full_a_i = 0; full_b_i = 0;
    for (int s = 0; s < 4; s++) begin
      sel_i = 2'(s); data_a_i = 8'hA5 ^ 8'(s); data_b_i = 8'h5A + 8'(s);
      step();
      chk("R5 idle no pop", int'(pop_a_o | pop_b_o), 0);
      chk("R5 idle bus released", int'(bus_en_o), 0);
    end

    // scenario with queue models of both FIFOs: fill then drain
    nxt = 8'h10;
    for (int c = 0; c < 60; c++) begin
      empty_a_i = (qa.size() == 0); full_a_i = (qa.size() == DEPTH);
      empty_b_i = (qb.size() == 0); full_b_i = (qb.size() == DEPTH);
      data_a_i = (qa.size() != 0) ? qa[0] : 8'hEE;
      data_b_i = (qb.size() != 0) ? qb[0] : 8'hDD;
      if (c < 8) begin rd_i = 0; sel_i = 2'b00; end
      else begin rd_i = 1; sel_i = 2'((c % 3) + 1); end
      step();
      if (wr_o) begin qa.push_back(nxt); qb.push_back(nxt ^ 8'hFF); nxt++; end
      if (pop_a_o) void'(qa.pop_front());
      if (pop_b_o) void'(qb.pop_front());
    end
    chk("R2 queues drained", qa.size() + qb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule